// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a cyclic redundancy remainder one bit per clock. All arithmetic is modulo-2. A two-bit select chooses one of four standard generator polynomials at the start of each message: a 12-bit code, a 16-bit code, the CCITT 16-bit code, or the common 32-bit code. A single remainder register serves all four. Its low n bits are active, where n is the degree of the selected generator.

In generate mode the block absorbs a message. After the end-of-message strobe it shifts out the n-bit check sequence, most significant bit first and one bit per cycle, with `fcs_valid` high. The sender appends these bits to the message, and the resulting frame divides exactly by the generator. In check mode the block absorbs a whole received frame, message and check bits together. One cycle after the last bit it raises `crc_err` if the remainder is nonzero. The flag then holds until the next start strobe.

Top module: `crc_sel_engine`

## Requirements
- R1: Out of reset, `fcs_valid` and `crc_err` are 0.
- R2: In generate mode (`check_mode`=0), from the cycle after the final message bit, `fcs_valid` is high for exactly n cycles. Over those cycles `fcs_bit` carries the remainder of M(x)·x^n divided by G(x), highest coefficient first. The remainder register starts from zero. The degree n is 12, 16, 16 or 32.
- R3: `poly_sel` 0 selects x^12+x^11+x^3+x^2+x+1, 1 selects x^16+x^15+x^2+1, 2 selects x^16+x^12+x^5+1, and 3 selects the 32-bit generator with taps 0x04C11DB7. With select 2, the ASCII string "123456789", each byte sent most significant bit first, yields the check sequence 0x31C3.
- R4: In check mode, a frame made of a message followed by its generated check bits gives `crc_err`=0 one cycle after its final bit, for every select value.
- R5: In check mode, a frame with any single bit inverted gives `crc_err`=1 one cycle after its final bit. The flag keeps that value through idle cycles until the next start strobe.
- R6: A start strobe clears the remainder register, so earlier messages do not affect the result. It also clears `crc_err` in the following cycle, unless that start cycle is itself the final bit, and it ends any check-sequence output still in progress.
- R7: `poly_sel` and `check_mode` are sampled only in the start-strobe cycle. Changes to them later in a message have no effect on the check sequence.
- R8: A bit presented with `bit_valid` in the same cycle as `sof` is the first bit of the new message, and bits from an unfinished earlier message are discarded. A message of a single bit has `sof` and `eom` in the same cycle.
- R9: Bits presented with `bit_valid` while the check sequence is being shifted out, without `sof`, are ignored and do not alter the output bits.
- R10: In generate mode `crc_err` stays 0. In check mode `fcs_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start strobe: clears the remainder and latches the mode and select |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial message or frame bit |
| eom | input | 1 | Marks the valid bit as the last bit of the message or frame |
| check_mode | input | 1 | 0 = generate, 1 = check; sampled at the start strobe |
| poly_sel | input | 2 | Generator choice (0: 12-bit, 1: 16-bit, 2: CCITT, 3: 32-bit); sampled at the start strobe |
| fcs_bit | output | 1 | Serial check-sequence bit, most significant first |
| fcs_valid | output | 1 | High while `fcs_bit` carries a check-sequence bit |
| crc_err | output | 1 | Nonzero remainder after a checked frame; holds until the next start |

## Verification
Two kinds of event can fall in the same cycle. A start strobe can arrive together with a data bit, so the clear and the first absorption happen at once. A fresh message can also start while an earlier one is still unfinished, or while check bits are still being shifted out. The bench provokes the first case by opening every message with `sof` and `bit_valid` together. It abandons a partial message and restarts it, and it sends a one-bit message with `sof` and `eom` coincident. The results are judged against a long-division model of the bench's own that sees only the new message. Stray bits driven during check-sequence output must leave the shifted bits unchanged.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;

   localparam int unsigned CRC_MAX_W = 32;

   typedef enum logic [1:0] {
      POLY_C12   = 2'd0,
      POLY_C16   = 2'd1,
      POLY_CCITT = 2'd2,
      POLY_C32   = 2'd3
   } crc_poly_e;

   // Generator coefficients below the leading term, bit i = coefficient of x^i.
   function automatic logic [CRC_MAX_W-1:0] poly_taps(input crc_poly_e s);
      logic [CRC_MAX_W-1:0] t;
      case (s)
         POLY_C12:   t = 32'h0000_080F;
         POLY_C16:   t = 32'h0000_8005;
         POLY_CCITT: t = 32'h0000_1021;
         default:    t = 32'h04C1_1DB7;
      endcase
      return t;
   endfunction

   function automatic int unsigned poly_degree(input crc_poly_e s);
      int unsigned d;
      case (s)
         POLY_C12:   d = 12;
         POLY_C16:   d = 16;
         POLY_CCITT: d = 16;
         default:    d = 32;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/crc_poly_table.sv
module crc_poly_table
   import crc_sel_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned DEG_W = $clog2(REG_W + 1)
) (
   input  crc_poly_e        sel,
   output logic [REG_W-1:0] taps,
   output logic [REG_W-1:0] len_mask,
   output logic [REG_W-1:0] top_bit,
   output logic [DEG_W-1:0] degree
);

   if (REG_W < CRC_MAX_W) begin : g_width_bad
      $error("crc_poly_table: REG_W must hold the widest generator");
   end

   assign taps   = REG_W'(poly_taps(sel));
   assign degree = DEG_W'(poly_degree(sel));

   for (genvar i = 0; i < REG_W; i++) begin : g_lane
      assign len_mask[i] = (DEG_W'(i) < degree);
      assign top_bit[i]  = (DEG_W'(i + 1) == degree);
   end

endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             absorb,
   input  logic             drain,
   input  logic             din,
   input  logic [REG_W-1:0] taps,
   input  logic [REG_W-1:0] len_mask,
   input  logic [REG_W-1:0] top_bit,
   output logic [REG_W-1:0] rem_nxt,
   output logic             msb
);

   logic [REG_W-1:0] rem_q;
   logic [REG_W-1:0] base;
   logic             base_msb;
   logic             fb;

   assign base     = clr ? '0 : rem_q;
   assign base_msb = |(base & top_bit);
   assign fb       = absorb & (din ^ base_msb);

   for (genvar i = 0; i < REG_W; i++) begin : g_cell
      logic shifted;
      if (i == 0) begin : g_low
         assign shifted = 1'b0;
      end else begin : g_up
         assign shifted = base[i-1];
      end
      assign rem_nxt[i] = (shifted ^ (fb & taps[i])) & len_mask[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (clr || absorb || drain) begin
         rem_q <= rem_nxt;
      end
   end

   assign msb = |(rem_q & top_bit);

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
   import crc_sel_pkg::*;
#(
   parameter int unsigned DEG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             bit_valid,
   input  logic             eom,
   input  logic             mode_in,
   input  crc_poly_e        sel_in,
   input  logic [DEG_W-1:0] degree,
   output crc_poly_e        sel_eff,
   output logic             check_q,
   output logic             clr,
   output logic             absorb,
   output logic             drain,
   output logic             err_upd,
   output logic             fcs_valid
);

   typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_DRAIN} seq_state_e;

   seq_state_e       state_q, state_d;
   crc_poly_e        sel_q;
   logic [DEG_W-1:0] cnt_q, cnt_d;
   logic             check_eff;
   logic             last;

   assign sel_eff   = sof ? sel_in : sel_q;
   assign check_eff = sof ? mode_in : check_q;
   assign clr       = sof;
   assign absorb    = bit_valid && (sof || state_q == ST_BODY);
   assign drain     = (state_q == ST_DRAIN) && !sof;
   assign fcs_valid = (state_q == ST_DRAIN);
   assign last      = absorb && eom;
   assign err_upd   = last && check_eff;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (last) begin
         state_d = check_eff ? ST_IDLE : ST_DRAIN;
         cnt_d   = '0;
      end else if (sof) begin
         state_d = ST_BODY;
      end else if (state_q == ST_DRAIN) begin
         cnt_d = cnt_q + DEG_W'(1);
         if (cnt_q == degree - DEG_W'(1)) begin
            state_d = ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sel_q   <= POLY_C12;
         check_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (sof) begin
            sel_q   <= sel_in;
            check_q <= mode_in;
         end
      end
   end

endmodule

// File: rtl/crc_sel_engine.sv
module crc_sel_engine
   import crc_sel_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof,
   input  logic       bit_valid,
   input  logic       bit_in,
   input  logic       eom,
   input  logic       check_mode,
   input  logic [1:0] poly_sel,
   output logic       fcs_bit,
   output logic       fcs_valid,
   output logic       crc_err
);

   localparam int unsigned DEG_W = $clog2(REG_W + 1);

   crc_poly_e        sel_eff;
   logic [REG_W-1:0] taps, len_mask, top_bit, rem_nxt;
   logic [DEG_W-1:0] degree;
   logic             check_q, clr, absorb, drain, err_upd, msb;

   crc_seq_ctrl #(.DEG_W(DEG_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .bit_valid (bit_valid),
      .eom       (eom),
      .mode_in   (check_mode),
      .sel_in    (crc_poly_e'(poly_sel)),
      .degree    (degree),
      .sel_eff   (sel_eff),
      .check_q   (check_q),
      .clr       (clr),
      .absorb    (absorb),
      .drain     (drain),
      .err_upd   (err_upd),
      .fcs_valid (fcs_valid)
   );

   crc_poly_table #(.REG_W(REG_W), .DEG_W(DEG_W)) u_table (
      .sel      (sel_eff),
      .taps     (taps),
      .len_mask (len_mask),
      .top_bit  (top_bit),
      .degree   (degree)
   );

   crc_rem_reg #(.REG_W(REG_W)) u_rem (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .absorb   (absorb),
      .drain    (drain),
      .din      (bit_in),
      .taps     (taps),
      .len_mask (len_mask),
      .top_bit  (top_bit),
      .rem_nxt  (rem_nxt),
      .msb      (msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_err <= 1'b0;
      end else if (err_upd) begin
         crc_err <= |rem_nxt;
      end else if (sof) begin
         crc_err <= 1'b0;
      end
   end

   assign fcs_bit = fcs_valid & msb;

endmodule

// File: rtl/crc_sel_engine_chk.sv
module crc_sel_engine_chk #(
   parameter int unsigned REG_W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic sof,
   input logic bit_valid,
   input logic eom,
   input logic fcs_valid,
   input logic crc_err,
   input logic check_q
);

   logic [7:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_cnt <= '0;
      else if (fcs_valid) run_cnt <= run_cnt + 8'd1;
      else                run_cnt <= '0;
   end

   AST_FCS_AFTER_EOM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fcs_valid) |-> $past(bit_valid && eom)); // R2

   AST_FCS_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      fcs_valid |-> (run_cnt < 8'(REG_W))); // R2

   AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_err) |-> $past(sof || (bit_valid && eom))); // R5

   AST_SOF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && !(bit_valid && eom)) |=> !fcs_valid); // R6

   AST_SOF_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && !(bit_valid && eom)) |=> !crc_err); // R6

   AST_GEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      fcs_valid |-> !crc_err); // R10

   AST_CHECK_NO_FCS: assert property (@(posedge clk) disable iff (!rst_n)
      check_q |-> !fcs_valid); // R10

endmodule

bind crc_sel_engine crc_sel_engine_chk #(.REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sof       (sof),
   .bit_valid (bit_valid),
   .eom       (eom),
   .fcs_valid (fcs_valid),
   .crc_err   (crc_err),
   .check_q   (check_q)
);

// File: tb/crc_sel_engine_tb_top.sv
module crc_sel_engine_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, eom = 1'b0;
   logic       check_mode = 1'b0;
   logic [1:0] poly_sel = 2'd0;
   logic       fcs_bit, fcs_valid, crc_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit mbuf [0:255];
   int mlen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_sel_engine dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof        (sof),
      .bit_valid  (bit_valid),
      .bit_in     (bit_in),
      .eom        (eom),
      .check_mode (check_mode),
      .poly_sel   (poly_sel),
      .fcs_bit    (fcs_bit),
      .fcs_valid  (fcs_valid),
      .crc_err    (crc_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int ref_deg(input int s);
      return (s == 0) ? 12 : (s == 3) ? 32 : 16;
   endfunction

   function automatic logic [32:0] ref_gen(input int s);
      case (s)
         0:       return 33'h0_0000_180F;
         1:       return 33'h0_0001_8005;
         2:       return 33'h0_0001_1021;
         default: return 33'h1_04C1_1DB7;
      endcase
   endfunction

   // Long division of mbuf·x^n by the full generator.
   function automatic logic [31:0] ref_rem(input int s);
      bit work [0:287];
      int n = ref_deg(s);
      logic [32:0] g = ref_gen(s);
      logic [31:0] r = '0;
      for (int i = 0; i < 288; i++) work[i] = (i < mlen) ? mbuf[i] : 1'b0;
      for (int i = 0; i < mlen; i++)
         if (work[i])
            for (int j = 0; j <= n; j++) work[i+j] = work[i+j] ^ g[n-j];
      for (int j = 0; j < n; j++) r[n-1-j] = work[mlen+j];
      return r;
   endfunction

   task automatic fill_rand(input int len);
      mlen = len;
      for (int i = 0; i < len; i++) mbuf[i] = 1'($urandom);
   endtask

   task automatic send_frame(input int s, input bit chkm, input bit alt_en, input bit with_eom);
      for (int i = 0; i < mlen; i++) begin
         @(negedge clk);
         sof        = (i == 0);
         check_mode = (alt_en && i > 0) ? ~chkm : chkm;
         poly_sel   = (alt_en && i > 0) ? 2'(s + 1) : 2'(s);
         bit_valid  = 1'b1;
         bit_in     = mbuf[i];
         eom        = with_eom && (i == mlen - 1);
      end
      @(negedge clk);
      sof = 1'b0; bit_valid = 1'b0; eom = 1'b0; bit_in = 1'b0;
   endtask

   task automatic collect(input int n, input bit noise, input string tag, output logic [31:0] v);
      int bad_valid = 0;
      v = '0;
      for (int i = 0; i < n; i++) begin
         if (fcs_valid !== 1'b1) bad_valid++;
         v = {v[30:0], fcs_bit};
         if (noise) begin
            bit_valid = 1'b1;
            bit_in    = 1'($urandom);
         end
         @(negedge clk);
      end
      bit_valid = 1'b0;
      chk({tag, " fcs_valid length"}, 32'(bad_valid), 32'd0);
      chk({tag, " fcs_valid drop"}, {31'd0, fcs_valid}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 fcs_valid at reset", {31'd0, fcs_valid}, 32'd0);
      chk("R1 crc_err at reset", {31'd0, crc_err}, 32'd0);
   endtask

   task automatic t_gen(input int s, input int len, input bit noise);
      logic [31:0] v;
      fill_rand(len);
      send_frame(s, 1'b0, 1'b0, 1'b1);
      collect(ref_deg(s), noise, noise ? "R9" : "R2", v);
      chk(noise ? "R9 fcs under stray bits" : "R2 fcs value", v, ref_rem(s));
   endtask

   task automatic t_ccitt_vector;
      string txt = "123456789";
      logic [31:0] v;
      mlen = 72;
      for (int b = 0; b < 9; b++)
         for (int k = 0; k < 8; k++) mbuf[b*8+k] = txt[b][7-k];
      send_frame(2, 1'b0, 1'b0, 1'b1);
      collect(16, 1'b0, "R3", v);
      chk("R3 CCITT check string", v, 32'h0000_31C3);
   endtask

   task automatic t_loop(input int s, input int len, input int flip);
      logic [31:0] v;
      int n = ref_deg(s);
      fill_rand(len);
      send_frame(s, 1'b0, 1'b0, 1'b1);
      collect(n, 1'b0, "R2", v);
      chk("R10 no error flag in generate", {31'd0, crc_err}, 32'd0);
      for (int j = 0; j < n; j++) mbuf[len + j] = v[n-1-j];
      mlen = len + n;
      send_frame(s, 1'b1, 1'b0, 1'b1);
      chk("R4 clean frame", {31'd0, crc_err}, 32'd0);
      chk("R10 no fcs in check", {31'd0, fcs_valid}, 32'd0);
      mbuf[flip] = ~mbuf[flip];
      send_frame(s, 1'b1, 1'b0, 1'b1);
      chk("R5 corrupted frame", {31'd0, crc_err}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R5 flag held", {31'd0, crc_err}, 32'd1);
      sof = 1'b1; bit_valid = 1'b1; bit_in = 1'b0; check_mode = 1'b1;
      @(negedge clk);
      sof = 1'b0; bit_valid = 1'b0;
      chk("R6 flag cleared by start", {31'd0, crc_err}, 32'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_restart(input int s);
      logic [31:0] v;
      fill_rand(9);
      send_frame(s, 1'b0, 1'b0, 1'b0);
      fill_rand(23);
      send_frame(s, 1'b0, 1'b0, 1'b1);
      collect(ref_deg(s), 1'b0, "R8", v);
      chk("R8 restart discards partial message", v, ref_rem(s));
   endtask

   task automatic t_sel_change(input int s);
      logic [31:0] v;
      fill_rand(40);
      send_frame(s, 1'b0, 1'b1, 1'b1);
      collect(ref_deg(s), 1'b0, "R7", v);
      chk("R7 mid-message select change ignored", v, ref_rem(s));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_ccitt_vector();
      for (int s = 0; s < 4; s++) t_gen(s, 37 + s * 11, 1'b0);
      t_gen(0, 1, 1'b0);
      t_gen(3, 1, 1'b0);
      t_gen(1, 50, 1'b1);
      t_gen(3, 64, 1'b1);
      for (int s = 0; s < 4; s++) t_loop(s, 30 + s * 7, 5 + s);
      t_loop(2, 20, 20 + 15);
      t_restart(0);
      t_restart(3);
      t_sel_change(1);
      t_sel_change(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule